// File: doc/BRIEF.md
# Equalizer Control Register Bank with Serial Slave

This block holds the digital control state of an adaptive cable equalizer and resolves that state into the control lines the analog core needs. Host software reaches it through a four-wire serial slave: clock, active-low select, data in, and data out with a separate drive enable. Three byte-wide registers are writable. They hold the general controls (mute, bypass, sleep policy, extended reach), the output driver codes (swing, offset) and the launch amplitude settings (coarse, fine). Two more addresses are read-only. One returns the measured cable-length code and the other a fixed die revision. Bit 7 of the general register reads back the live carrier-detect input.

The serial pins are sampled by the system clock, so every SPI edge is an event in that clock domain. Both frame types start with a command bit and a 7-bit address. A write carries 8 more data bits and commits on its 16th rising edge. A read stops sending after the address: the addressed byte is captured at the 8th rising edge and is driven most significant bit first from the following falling edge. When the SPI-enable input is low, the block falls back to pin control. The mute, bypass and auto-sleep pins then drive the controls directly, the serial port stays idle, and the driver and launch outputs hold their reset codes.

The decoded controls follow a fixed priority. Sleep beats mute, and mute beats bypass, so only one of the three is ever active.

Top module: `eq_spi_ctrl`

## Requirements
- R1: A frame while `ss_n` is low whose first bit is 0 is a write: a 7-bit address and 8 data bits follow, MSB first, sampled on SCK rising edges. The data reaches the register only after the 16th rising edge, and `miso_oe` stays low for the whole write frame.
- R2: A frame whose first bit is 1 is a read of the 7-bit address that follows. The byte is captured at the 8th rising edge. `miso_oe` rises on the 8th falling edge, and the byte appears on `miso` MSB first, one bit per falling edge. `miso_oe` is low whenever `ss_n` is high.
- R3: Address 0x00 layout: bit 7 is the carrier input (read-only), bit 6 mute, bit 5 bypass, bits 4:3 sleep mode, bit 2 extended reach. The reset value is 0x08, so sleep mode is 01 and all other fields are 0.
- R4: Address 0x01 holds swing in bits 7:5 (reset 011) and offset in bits 4:2 (reset 001). Address 0x02 holds coarse launch in bit 7 (reset 0) and fine launch in bits 6:3 (reset 0000). In SPI mode these drive `swing_code`, `offset_code`, `launch_coarse` and `launch_fine`.
- R5: Address 0x03 reads `{cable_len, 3'b000}`. Address 0x04 reads 0x02.
- R6: Reserved bits (0x00 bits 1:0, 0x01 bits 1:0, 0x02 bits 2:0) read 0 whatever was written to them.
- R7: Writes to 0x03, 0x04 and to unmapped addresses change no register. Reads of unmapped addresses return 0x00.
- R8: Sleep mode decode: 00 never sleeps, 10 always sleeps, 01 sleeps while `carrier_det` is low. The reserved code 11 acts like 01.
- R9: Priority: when `eq_sleep` is high, `out_mute` and `eq_bypass` are low. When `out_mute` is high, `eq_bypass` is low.
- R10: With `spi_en` low, `pin_mute` and `pin_bypass` act as the mute and bypass bits, and `pin_autosleep` selects sleep mode 01 (high) or 00 (low). The same priority applies. Extended reach is 0, the driver and launch outputs take their reset codes, serial frames are ignored, and `miso_oe` stays low.
- R11: If `ss_n` rises before the 16th bit of a write, nothing is written. The next frame starts from bit zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_en | input | 1 | 1: serial register control; 0: pin control |
| sck | input | 1 | Serial clock from the host |
| ss_n | input | 1 | Active-low slave select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial read data, valid when miso_oe is high |
| miso_oe | output | 1 | Drive enable for miso |
| carrier_det | input | 1 | 1 when an input signal is present |
| cable_len | input | 5 | Measured cable-length code |
| pin_mute | input | 1 | Mute request in pin mode |
| pin_bypass | input | 1 | Bypass request in pin mode |
| pin_autosleep | input | 1 | Auto-sleep enable in pin mode |
| eq_sleep | output | 1 | Power down the equalizer |
| out_mute | output | 1 | Force the data output to zero |
| eq_bypass | output | 1 | Bypass the equalizer filter |
| ext_reach | output | 1 | Extended-reach mode |
| swing_code | output | 3 | Output swing code |
| offset_code | output | 3 | Output offset code |
| launch_coarse | output | 1 | Coarse launch-amplitude setting |
| launch_fine | output | 4 | Fine launch-amplitude setting |

## Verification
The assertions assume that `sck`, `ss_n` and `mosi` each hold a level for at least three system clocks, so that the synchronizers never lose or merge an SPI edge. They also assume that `mosi` changes only while `sck` is low, and that `carrier_det` and `cable_len` are steady while a read byte is being captured. The stimulus meets these limits. It holds each SCK phase for eight system clocks and changes MOSI only during the low phase. It changes the carrier input and the mode pins only between frames, and it waits well past the synchronizer and decode latency before it samples the control outputs.

// File: rtl/eqspi_pkg.sv
`timescale 1ns/1ps
package eqspi_pkg;

    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 8;
    localparam int CLEN_W  = 5;
    localparam int CODE_W  = 3;
    localparam int FINE_W  = 4;
    localparam int CMD_W   = 1 + ADDR_W;
    localparam int FRAME_W = CMD_W + DATA_W;

    typedef enum logic [1:0] {
        SLP_ON    = 2'b00,
        SLP_AUTO  = 2'b01,
        SLP_FORCE = 2'b10,
        SLP_RSVD  = 2'b11
    } sleep_mode_t;

    // views of the writable bytes
    typedef struct packed {
        logic        mute;
        logic        bypass;
        sleep_mode_t sleep;
        logic        ext;
    } gen_reg_t;

    typedef struct packed {
        logic [CODE_W-1:0] swing;
        logic [CODE_W-1:0] offset;
    } drv_reg_t;

    typedef struct packed {
        logic              coarse;
        logic [FINE_W-1:0] fine;
    } launch_reg_t;

    typedef struct packed {
        logic              sleep;
        logic              mute;
        logic              bypass;
        logic              ext;
        logic [CODE_W-1:0] swing;
        logic [CODE_W-1:0] offset;
        logic              coarse;
        logic [FINE_W-1:0] fine;
    } ctrl_t;

    localparam logic [ADDR_W-1:0] ADR_GEN    = 7'h00;
    localparam logic [ADDR_W-1:0] ADR_DRV    = 7'h01;
    localparam logic [ADDR_W-1:0] ADR_LAUNCH = 7'h02;
    localparam logic [ADDR_W-1:0] ADR_CLEN   = 7'h03;
    localparam logic [ADDR_W-1:0] ADR_ID     = 7'h04;

    localparam logic [DATA_W-1:0] DIE_REV     = 8'h02;
    localparam logic [DATA_W-1:0] MASK_GEN    = 8'h7C;
    localparam logic [DATA_W-1:0] MASK_DRV    = 8'hFC;
    localparam logic [DATA_W-1:0] MASK_LAUNCH = 8'hF8;
    localparam logic [DATA_W-1:0] RST_GEN     = 8'h08;
    localparam logic [DATA_W-1:0] RST_DRV     = 8'h64;
    localparam logic [DATA_W-1:0] RST_LAUNCH  = 8'h00;

    function automatic logic sleep_req(sleep_mode_t mode, logic carrier);
        case (mode)
            SLP_ON:    return 1'b0;
            SLP_FORCE: return 1'b1;
            default:   return ~carrier;   // auto, and reserved treated as auto
        endcase
    endfunction

endpackage

// File: rtl/eqspi_sync.sv
`timescale 1ns/1ps
module eqspi_sync #(
    parameter int              W       = 3,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/eqspi_frame.sv
`timescale 1ns/1ps
module eqspi_frame
    import eqspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              sck_s,
    input  logic              ss_n_s,
    input  logic              mosi_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              miso,
    output logic              miso_oe
);
    localparam int CNT_W = $clog2(FRAME_W + 1);

    logic                 sck_q;
    logic [FRAME_W-2:0]   shift_q;
    logic [FRAME_W-1:0]   shift_next;
    logic [CNT_W-1:0]     cnt_q;
    logic                 rd_act_q;
    logic                 oe_q;
    logic [DATA_W-1:0]    tx_q;
    logic                 idle, rise, fall;

    assign idle       = ss_n_s | ~enable;
    assign rise       = sck_s & ~sck_q;
    assign fall       = ~sck_s & sck_q;
    assign shift_next = {shift_q, mosi_s};
    assign rd_addr    = shift_next[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q    <= 1'b0;
            shift_q  <= '0;
            cnt_q    <= '0;
            rd_act_q <= 1'b0;
            oe_q     <= 1'b0;
            tx_q     <= '0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            sck_q <= sck_s;
            wr_en <= 1'b0;
            if (idle) begin
                cnt_q    <= '0;
                rd_act_q <= 1'b0;
                oe_q     <= 1'b0;
            end else begin
                if (rise && cnt_q < CNT_W'(FRAME_W)) begin
                    shift_q <= shift_next[FRAME_W-2:0];
                    cnt_q   <= cnt_q + 1'b1;
                    if (cnt_q == CNT_W'(CMD_W - 1) && shift_next[CMD_W-1]) begin
                        rd_act_q <= 1'b1;
                        tx_q     <= rd_data;
                    end
                    if (cnt_q == CNT_W'(FRAME_W - 1) && !shift_next[FRAME_W-1]) begin
                        wr_en   <= 1'b1;
                        wr_addr <= shift_next[FRAME_W-2:DATA_W];
                        wr_data <= shift_next[DATA_W-1:0];
                    end
                end
                if (fall && rd_act_q) begin
                    if (!oe_q) oe_q <= 1'b1;
                    else       tx_q <= {tx_q[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    assign miso    = oe_q & tx_q[DATA_W-1];
    assign miso_oe = oe_q;

    // R2
    oe_idle_chk: assert property (@(posedge clk) disable iff (rst)
        idle |=> !miso_oe);

    // R1
    write_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !oe_q);
endmodule

// File: rtl/eqspi_regs.sv
`timescale 1ns/1ps
module eqspi_regs
    import eqspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              carrier,
    input  logic [CLEN_W-1:0] cable_len,
    output logic [DATA_W-1:0] rd_data,
    output gen_reg_t          gen,
    output drv_reg_t          drv,
    output launch_reg_t       launch
);
    logic [DATA_W-1:0] gen_q, drv_q, launch_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_q    <= RST_GEN;
            drv_q    <= RST_DRV;
            launch_q <= RST_LAUNCH;
        end else if (wr_en) begin
            case (wr_addr)
                ADR_GEN:    gen_q    <= wr_data & MASK_GEN;
                ADR_DRV:    drv_q    <= wr_data & MASK_DRV;
                ADR_LAUNCH: launch_q <= wr_data & MASK_LAUNCH;
                default:    ;
            endcase
        end
    end

    assign gen    = gen_reg_t'(gen_q[6:2]);
    assign drv    = drv_reg_t'(drv_q[7:2]);
    assign launch = launch_reg_t'(launch_q[7:3]);

    always_comb begin
        case (rd_addr)
            ADR_GEN:    rd_data = gen_q | {carrier, {(DATA_W-1){1'b0}}};
            ADR_DRV:    rd_data = drv_q;
            ADR_LAUNCH: rd_data = launch_q;
            ADR_CLEN:   rd_data = {cable_len, {(DATA_W-CLEN_W){1'b0}}};
            ADR_ID:     rd_data = DIE_REV;
            default:    rd_data = '0;
        endcase
    end

    // R7
    ro_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && (wr_addr > ADR_LAUNCH) |=> $stable(gen_q) && $stable(drv_q) && $stable(launch_q));

    // R3
    reset_default_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> gen_q == RST_GEN && drv_q == RST_DRV && launch_q == RST_LAUNCH);
endmodule

// File: rtl/eqspi_ctrl.sv
`timescale 1ns/1ps
module eqspi_ctrl
    import eqspi_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        spi_en,
    input  logic        carrier,
    input  gen_reg_t    gen,
    input  drv_reg_t    drv,
    input  launch_reg_t launch,
    input  logic        pin_mute,
    input  logic        pin_bypass,
    input  logic        pin_autosleep,
    output ctrl_t       ctl
);
    localparam drv_reg_t    DRV_DEF    = drv_reg_t'(RST_DRV[7:2]);
    localparam launch_reg_t LAUNCH_DEF = launch_reg_t'(RST_LAUNCH[7:3]);

    sleep_mode_t mode;
    logic        mute_b, byp_b, slp;
    ctrl_t       nxt;

    always_comb begin
        mode   = spi_en ? gen.sleep  : (pin_autosleep ? SLP_AUTO : SLP_ON);
        mute_b = spi_en ? gen.mute   : pin_mute;
        byp_b  = spi_en ? gen.bypass : pin_bypass;
        slp    = sleep_req(mode, carrier);

        nxt.sleep  = slp;
        nxt.mute   = ~slp & mute_b;
        nxt.bypass = ~slp & ~mute_b & byp_b;
        nxt.ext    = spi_en & gen.ext;
        nxt.swing  = spi_en ? drv.swing     : DRV_DEF.swing;
        nxt.offset = spi_en ? drv.offset    : DRV_DEF.offset;
        nxt.coarse = spi_en ? launch.coarse : LAUNCH_DEF.coarse;
        nxt.fine   = spi_en ? launch.fine   : LAUNCH_DEF.fine;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl        <= '0;
            ctl.swing  <= DRV_DEF.swing;
            ctl.offset <= DRV_DEF.offset;
        end else begin
            ctl <= nxt;
        end
    end

    // R9
    sleep_over_mute_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.sleep |-> !ctl.mute && !ctl.bypass);

    // R9
    mute_over_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.mute |-> !ctl.bypass);

    // R8
    force_sleep_chk: assert property (@(posedge clk) disable iff (rst)
        spi_en && gen.sleep == SLP_FORCE |=> ctl.sleep);

    // R10
    pin_mute_chk: assert property (@(posedge clk) disable iff (rst)
        !spi_en && !pin_autosleep |=> ctl.mute == $past(pin_mute));
endmodule

// File: rtl/eq_spi_ctrl.sv
`timescale 1ns/1ps
module eq_spi_ctrl
    import eqspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_en,
    input  logic              sck,
    input  logic              ss_n,
    input  logic              mosi,
    output logic              miso,
    output logic              miso_oe,
    input  logic              carrier_det,
    input  logic [CLEN_W-1:0] cable_len,
    input  logic              pin_mute,
    input  logic              pin_bypass,
    input  logic              pin_autosleep,
    output logic              eq_sleep,
    output logic              out_mute,
    output logic              eq_bypass,
    output logic              ext_reach,
    output logic [CODE_W-1:0] swing_code,
    output logic [CODE_W-1:0] offset_code,
    output logic              launch_coarse,
    output logic [FINE_W-1:0] launch_fine
);
    logic [2:0]        pins_s;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [DATA_W-1:0] rd_data, wr_data;
    logic              wr_en;
    gen_reg_t          gen;
    drv_reg_t          drv;
    launch_reg_t       launch;
    ctrl_t             ctl;

    eqspi_sync #(.W(3), .STAGES(2), .RST_VAL(3'b010)) u_sync (
        .clk(clk), .rst(rst),
        .async_in({sck, ss_n, mosi}),
        .sync_out(pins_s)
    );

    eqspi_frame u_frame (
        .clk(clk), .rst(rst), .enable(spi_en),
        .sck_s(pins_s[2]), .ss_n_s(pins_s[1]), .mosi_s(pins_s[0]),
        .rd_data(rd_data), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .miso(miso), .miso_oe(miso_oe)
    );

    eqspi_regs u_regs (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .carrier(carrier_det), .cable_len(cable_len),
        .rd_data(rd_data), .gen(gen), .drv(drv), .launch(launch)
    );

    eqspi_ctrl u_ctrl (
        .clk(clk), .rst(rst), .spi_en(spi_en), .carrier(carrier_det),
        .gen(gen), .drv(drv), .launch(launch),
        .pin_mute(pin_mute), .pin_bypass(pin_bypass), .pin_autosleep(pin_autosleep),
        .ctl(ctl)
    );

    assign eq_sleep      = ctl.sleep;
    assign out_mute      = ctl.mute;
    assign eq_bypass     = ctl.bypass;
    assign ext_reach     = ctl.ext;
    assign swing_code    = ctl.swing;
    assign offset_code   = ctl.offset;
    assign launch_coarse = ctl.coarse;
    assign launch_fine   = ctl.fine;

    // R10
    pin_mode_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !spi_en |=> !miso_oe);
endmodule

// File: tb/eq_spi_ctrl_tb.sv
`timescale 1ns/1ps
module eq_spi_ctrl_tb;
    localparam int H = 8;   // system clocks per SCK phase

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic spi_en = 1'b1, sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
    logic carrier_det = 1'b0;
    logic [4:0] cable_len = 5'd18;
    logic pin_mute = 1'b0, pin_bypass = 1'b0, pin_autosleep = 1'b0;
    logic miso, miso_oe, eq_sleep, out_mute, eq_bypass, ext_reach, launch_coarse;
    logic [2:0] swing_code, offset_code;
    logic [3:0] launch_fine;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    eq_spi_ctrl u_dut (
        .clk(clk), .rst(rst), .spi_en(spi_en), .sck(sck), .ss_n(ss_n), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe), .carrier_det(carrier_det), .cable_len(cable_len),
        .pin_mute(pin_mute), .pin_bypass(pin_bypass), .pin_autosleep(pin_autosleep),
        .eq_sleep(eq_sleep), .out_mute(out_mute), .eq_bypass(eq_bypass), .ext_reach(ext_reach),
        .swing_code(swing_code), .offset_code(offset_code),
        .launch_coarse(launch_coarse), .launch_fine(launch_fine)
    );

    // {write address, write data, expected read-back}
    localparam logic [23:0] VEC [11] = '{
        {8'h00, 8'h7F, 8'hFC},   // R3 R6 all general bits set, carrier high
        {8'h01, 8'hFF, 8'hFC},   // R4 R6
        {8'h01, 8'h5A, 8'h58},   // R4 R6
        {8'h02, 8'hFF, 8'hF8},   // R4 R6
        {8'h02, 8'h4D, 8'h48},   // R4 R6
        {8'h03, 8'hFF, 8'h90},   // R5 R7 cable code 18
        {8'h04, 8'h55, 8'h02},   // R5 R7
        {8'h05, 8'hAA, 8'h00},   // R7
        {8'h7F, 8'h11, 8'h00},   // R7
        {8'h00, 8'h83, 8'h80},   // R6 R3 only reserved and read-only bits set
        {8'h00, 8'h08, 8'h88}    // R3
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // rd=1: send nbits of command, then clock in 8 data bits
    task automatic spi_xfer(input logic [15:0] bits, input int nbits, input bit rd,
                            output logic [7:0] rdata, output int oe_bad);
        rdata  = '0;
        oe_bad = 0;
        ss_n = 1'b0;
        tick(H);
        for (int i = 0; i < nbits; i++) begin
            mosi = bits[15-i];
            tick(H);
            if (miso_oe) oe_bad++;
            sck = 1'b1;
            tick(H);
            sck = 1'b0;
        end
        if (rd) begin
            for (int j = 0; j < 8; j++) begin
                tick(H);
                if (!miso_oe) oe_bad++;
                rdata = {rdata[6:0], miso};
                sck = 1'b1;
                tick(H);
                sck = 1'b0;
            end
        end
        tick(H);
        ss_n = 1'b1;
        tick(2*H);
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d, input string req);
        logic [7:0] unused_rd;
        int bad;
        spi_xfer({1'b0, a, d}, 16, 1'b0, unused_rd, bad);
        chk(req, bad, 0);
    endtask

    task automatic rd_chk(input logic [6:0] a, input logic [7:0] exp, input string req);
        logic [7:0] v;
        int bad;
        spi_xfer({1'b1, a, 8'h00}, 8, 1'b1, v, bad);
        chk(req, v, exp);
        chk("R2 oe during read data", bad, 0);
    endtask

    task automatic ctl_chk(input logic s, input logic m, input logic b, input string req);
        tick(8);
        chk(req, {eq_sleep, out_mute, eq_bypass}, {s, m, b});
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int bad;
        tick(10);
        rst = 1'b0;
        tick(6);
        // R3 R4: reset state with no carrier
        chk("R3 reset controls", {eq_sleep, out_mute, eq_bypass, ext_reach}, 4'b1000);
        chk("R4 reset codes", {swing_code, offset_code, launch_coarse, launch_fine}, {3'd3, 3'd1, 1'b0, 4'd0});
        chk("R2 reset miso_oe", miso_oe, 0);
        rd_chk(7'h00, 8'h08, "R3 reset reg0");
        rd_chk(7'h01, 8'h64, "R4 reset reg1");
        rd_chk(7'h02, 8'h00, "R4 reset reg2");

        carrier_det = 1'b1;
        for (int k = 0; k < 11; k++) begin
            wr(VEC[k][22:16], VEC[k][15:8], "R1 write frame oe");
            rd_chk(VEC[k][22:16], VEC[k][7:0], "R1 R3 R4 R5 R6 R7 table");
        end
        // R7: ignored writes left reg1 and reg2 intact
        rd_chk(7'h01, 8'h58, "R7 reg1 kept");
        rd_chk(7'h02, 8'h48, "R7 reg2 kept");
        tick(4);
        chk("R4 launch outputs", {launch_coarse, launch_fine}, {1'b0, 4'd9});
        chk("R4 driver outputs", {swing_code, offset_code}, {3'd2, 3'd6});

        // R9 priority, R8 sleep decode
        wr(7'h00, 8'h60, "R1 write oe");
        ctl_chk(0, 1, 0, "R9 mute over bypass");
        wr(7'h00, 8'h24, "R1 write oe");
        ctl_chk(0, 0, 1, "R9 bypass alone");
        chk("R3 ext reach", ext_reach, 1);
        wr(7'h00, 8'h70, "R1 write oe");
        ctl_chk(1, 0, 0, "R8 R9 forced sleep");
        wr(7'h00, 8'h48, "R1 write oe");
        ctl_chk(0, 1, 0, "R8 auto with carrier");
        carrier_det = 1'b0;
        ctl_chk(1, 0, 0, "R8 auto without carrier");
        wr(7'h00, 8'h18, "R1 write oe");
        ctl_chk(1, 0, 0, "R8 reserved as auto, no carrier");
        carrier_det = 1'b1;
        ctl_chk(0, 0, 0, "R8 reserved as auto, carrier");

        // R10 pin mode
        spi_en = 1'b0; pin_mute = 1'b1; pin_bypass = 1'b1; pin_autosleep = 1'b0;
        ctl_chk(0, 1, 0, "R10 pin mute over bypass");
        chk("R10 pin defaults", {ext_reach, swing_code, offset_code, launch_fine}, {1'b0, 3'd3, 3'd1, 4'd0});
        pin_mute = 1'b0;
        ctl_chk(0, 0, 1, "R10 pin bypass");
        pin_autosleep = 1'b1; carrier_det = 1'b0;
        ctl_chk(1, 0, 0, "R10 pin auto sleep");
        spi_xfer({1'b1, 7'h01, 8'h00}, 8, 1'b1, v, bad);
        chk("R10 no drive in pin mode", bad, 8);
        wr(7'h01, 8'h00, "R10 pin write oe");
        spi_en = 1'b1; carrier_det = 1'b1; pin_autosleep = 1'b0; pin_bypass = 1'b0;
        tick(4);
        rd_chk(7'h01, 8'h58, "R10 pin-mode write ignored");

        // R11 aborted write, then a clean frame
        spi_xfer({1'b0, 7'h01, 8'hFF}, 10, 1'b0, v, bad);
        rd_chk(7'h01, 8'h58, "R11 aborted write");
        spi_xfer({1'b0, 7'h01, 8'hFF}, 15, 1'b0, v, bad);
        rd_chk(7'h01, 8'h58, "R11 aborted at 15 bits");
        wr(7'h01, 8'h84, "R1 write oe");
        rd_chk(7'h01, 8'h84, "R11 R1 frame after abort");
        tick(4);
        chk("R4 driver outputs after write", {swing_code, offset_code}, {3'd4, 3'd1});

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule